// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counter Timer

This peripheral holds four independent down-counters behind one register slave with an APB-style handshake. Each channel has a control word, a count that can be read, and a background reload value. The control word turns the channel on and off and selects the clock divider (1, 16 or 256). It also sets the counter width (16 or 32 bits) and chooses what happens at zero: stop there (one-shot), reload from the background value (periodic), or wrap to all-ones (free-running).

When a channel counts down into zero, it raises its own bit in a shared raw status vector. A mask register selects which raw bits reach a single combined interrupt line. Software clears a raw bit by writing a one to it. Because the background value can be changed while a channel runs, software can alter the period of the next cycle without disturbing the cycle in progress.

Top module: `quad_tick_timer`

## Requirements
- R1: After synchronous reset, every count, control word, background value, the mask and the raw status read as zero, and `irq_o` is low.
- R2: Word offsets `paddr[1:0]=0`. Shared registers: 0x00 mask (read/write), 0x04 raw status (read), 0x08 raw AND mask (read), 0x0C clear (write one to clear, reads zero). Channel n (0..3) starts at 0x10+0x10*n with these registers: +0x0 load (write; reads the background value), +0x4 count (read only), +0x8 control, +0xC background reload. Every other offset reads zero.
- R3: A write to load sets the count and the background value to the written word at once, and it restarts that channel's divider.
- R4: Control bit 7 enables the channel. Bits 3:2 pick the divider: 00 gives 1, 01 gives 16, 10 and 11 give 256. A write to control restarts the divider, and the first decrement comes N cycles after that write.
- R5: A decrement from 1 to 0 sets raw bit n. Channel n owns bit n.
- R6: Control bit 1 set gives a 32-bit count and clear gives a 16-bit count. In free-running mode (bits 6 and 0 clear), a tick at zero wraps the count to all-ones of the selected width.
- R7: With bit 6 set (periodic), a tick at zero loads the background value. A write to the background register leaves the running count unchanged.
- R8: With bit 0 set (one-shot), the count stays at zero. A control write that enables a channel that was disabled, while its count is zero, reloads the count from the background value.
- R9: A disabled channel holds its count.
- R10: `irq_o` is the OR of raw AND mask. Writing ones to the clear register clears only those raw bits.
- R11: The control register reads back bits 7, 6, 3:2, 1 and 0 in place, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach is a channel that has already passed zero when the bench looks at it. That covers a period that begins from a background value written mid-run, a 16-bit count that wrapped to 0xFFFF, or a one-shot held at zero and then re-enabled. Each is reached only after an exact number of divided ticks. The bench records the clock edge at which each control write lands. A tick-by-tick model in the bench then replays every decrement, wrap and reload up to the edge of each read. Random channels, modes, dividers, loads and wait lengths from a fixed seed land reads on both sides of zero.

// File: rtl/qtt_pkg.sv
package qtt_pkg;

    localparam int CNT_W   = 32;
    localparam int SHORT_W = 16;

    // control word, laid out exactly as the bus bits 7:0
    typedef struct packed {
        logic       en;
        logic       per;
        logic [1:0] rsvd;
        logic [1:0] pre;
        logic       w32;
        logic       os;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_A = 2'd0,
        REG_B = 2'd1,
        REG_C = 2'd2,
        REG_D = 2'd3
    } slot_e;

    function automatic ctrl_t ctrl_from_bus(input logic [7:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = 2'b00;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] width_mask(input logic w32);
        return w32 ? {CNT_W{1'b1}} : {{(CNT_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    endfunction

endpackage

// File: rtl/qtt_prescaler.sv
module qtt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << (PRE_W / 2)) - 1);
    localparam logic [PRE_W-1:0] LIM_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        case (sel)
            2'd0:    limit = '0;
            2'd1:    limit = LIM_MID;
            default: limit = LIM_MAX;
        endcase
    end

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/qtt_channel.sv
module qtt_channel
    import qtt_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ctl_we,
    input  logic             bg_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] bg_o,
    output ctrl_t            ctrl_o,
    output logic             hit_o
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bg_q;
    logic [CNT_W-1:0] msk;
    logic [CNT_W-1:0] cur;
    logic             tick;
    logic             at_zero;

    assign ctrl_n  = ctrl_from_bus(wdata[7:0]);
    assign msk     = width_mask(ctrl_q.w32);
    assign cur     = cnt_q & msk;
    assign at_zero = (cur == '0);

    qtt_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (ld_we | ctl_we),
        .run     (ctrl_q.en),
        .sel     (ctrl_q.pre),
        .tick    (tick)
    );

    // only a tick that is not pre-empted by a bus write may count to zero
    assign hit_o = tick && !ld_we && !ctl_we && (cur == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctl_we) begin
            ctrl_q <= ctrl_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bg_q <= '0;
        end else if (ld_we || bg_we) begin
            bg_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_we) begin
            cnt_q <= wdata;
        end else if (ctl_we) begin
            if (!ctrl_q.en && ctrl_n.en && at_zero) begin
                cnt_q <= bg_q;
            end
        end else if (tick) begin
            if (!at_zero) begin
                cnt_q <= cur - 1'b1;
            end else if (ctrl_q.os) begin
                cnt_q <= cnt_q;
            end else if (ctrl_q.per) begin
                cnt_q <= bg_q & msk;
            end else begin
                cnt_q <= msk;
            end
        end
    end

    assign count_o = cur;
    assign bg_o    = bg_q;
    assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/qtt_irq.sv
module qtt_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] masked_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            // a new hit outranks a clear in the same cycle
            raw_q <= (raw_q & ~clr_bits) | hit;
            if (mask_we) begin
                mask_q <= wbits;
            end
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = |masked_o;
endmodule

// File: rtl/quad_tick_timer.sv
module quad_tick_timer
    import qtt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              irq_o
);
    localparam int BLK_W = ADDR_W - 4;

    logic              wr;
    logic              aligned;
    logic [BLK_W-1:0]  blk;
    slot_e             slot;
    logic              shared_sel;
    logic [NUM_CH-1:0] ch_sel;
    logic [NUM_CH-1:0] hit_w;
    logic [NUM_CH-1:0] raw_w;
    logic [NUM_CH-1:0] mask_w;
    logic [NUM_CH-1:0] masked_w;
    logic [NUM_CH-1:0] en_w;
    logic [NUM_CH-1:0] os_w;
    logic [NUM_CH*CNT_W-1:0] cnt_flat;
    logic [CNT_W-1:0]  rd_ch [NUM_CH];

    assign wr         = psel && penable && pwrite;
    assign aligned    = (paddr[1:0] == 2'b00);
    assign blk        = paddr[ADDR_W-1:4];
    assign slot       = slot_e'(paddr[3:2]);
    assign shared_sel = aligned && (blk == '0);

    qtt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_we  (wr && shared_sel && (slot == REG_A)),
        .clr_we   (wr && shared_sel && (slot == REG_D)),
        .wbits    (pwdata[NUM_CH-1:0]),
        .hit      (hit_w),
        .raw_o    (raw_w),
        .mask_o   (mask_w),
        .masked_o (masked_w),
        .irq_o    (irq_o)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [CNT_W-1:0] count_n;
        logic [CNT_W-1:0] bg_n;
        ctrl_t            ctrl_n;

        assign ch_sel[n] = aligned && (blk == BLK_W'(n + 1));

        qtt_channel #(.PRE_W(PRE_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .ld_we   (wr && ch_sel[n] && (slot == REG_A)),
            .ctl_we  (wr && ch_sel[n] && (slot == REG_C)),
            .bg_we   (wr && ch_sel[n] && (slot == REG_D)),
            .wdata   (pwdata),
            .count_o (count_n),
            .bg_o    (bg_n),
            .ctrl_o  (ctrl_n),
            .hit_o   (hit_w[n])
        );

        assign cnt_flat[n*CNT_W +: CNT_W] = count_n;
        assign en_w[n] = ctrl_n.en;
        assign os_w[n] = ctrl_n.os;

        always_comb begin
            case (slot)
                REG_B:   rd_ch[n] = count_n;
                REG_C:   rd_ch[n] = {{(CNT_W-8){1'b0}}, ctrl_n};
                default: rd_ch[n] = bg_n;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (shared_sel) begin
            case (slot)
                REG_A:   prdata = {{(CNT_W-NUM_CH){1'b0}}, mask_w};
                REG_B:   prdata = {{(CNT_W-NUM_CH){1'b0}}, raw_w};
                REG_C:   prdata = {{(CNT_W-NUM_CH){1'b0}}, masked_w};
                default: prdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) begin
                prdata = rd_ch[i];
            end
        end
    end
endmodule

// File: rtl/qtt_checker.sv
module qtt_checker #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [NUM_CH-1:0]    wbits,
    input logic [NUM_CH-1:0]    raw,
    input logic [NUM_CH-1:0]    mask,
    input logic [NUM_CH-1:0]    hit,
    input logic [NUM_CH-1:0]    en,
    input logic [NUM_CH-1:0]    os,
    input logic [NUM_CH*32-1:0] cnts,
    input logic                 irq_o
);
    logic bus_wr;
    logic clr_wr;
    logic [NUM_CH-1:0] ch_wr;

    assign bus_wr = psel && penable && pwrite;
    assign clr_wr = bus_wr && (paddr == ADDR_W'(12));

    // R1: reset leaves status, mask and interrupt line clear
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (raw == '0 && mask == '0 && !irq_o));

    // R5: every reported hit is latched into raw status
    a_r5_hit_sets_raw: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((raw & $past(hit)) == $past(hit)));

    // R10: cleared bits without a simultaneous hit drop
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && ((wbits & ~hit) != '0)) |=> ((raw & $past(wbits & ~hit)) == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ck
        assign ch_wr[n] = bus_wr && (paddr[ADDR_W-1:4] == (ADDR_W-4)'(n + 1));

        // R9: a disabled, untouched channel keeps its count
        a_r9_disabled_holds: assert property (@(posedge clk) disable iff (rst)
            (!en[n] && !ch_wr[n]) |=> $stable(cnts[n*32 +: 32]));

        // R8: an enabled one-shot channel parked at zero stays there
        a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
            (en[n] && os[n] && cnts[n*32 +: 32] == 32'd0 && !ch_wr[n])
            |=> (cnts[n*32 +: 32] == 32'd0));
    end
endmodule

bind quad_tick_timer qtt_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wbits   (pwdata[NUM_CH-1:0]),
    .raw     (raw_w),
    .mask    (mask_w),
    .hit     (hit_w),
    .en      (en_w),
    .os      (os_w),
    .cnts    (cnt_flat),
    .irq_o   (irq_o)
);

// File: tb/sim_quad_tick_timer.sv
module sim_quad_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o;
    int          cyc = 0;
    int          total = 0;
    int          fails = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_tick_timer u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output int commit);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        commit = cyc + 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output int at);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        d = prdata;
        at = cyc;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] ch_addr(input int ch, input int slot);
        return 12'(16 + 16 * ch + 4 * slot);
    endfunction

    function automatic int div_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 16 : 256;
    endfunction

    // tick-by-tick reference of one channel from its last divider restart
    function automatic logic [31:0] model(input logic [31:0] ld, input logic [31:0] bg,
                                          input bit w32, input bit per, input bit os,
                                          input int ticks, output bit hit);
        logic [31:0] m;
        logic [31:0] c;
        m = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        c = ld & m;
        hit = 0;
        for (int t = 0; t < ticks; t++) begin
            if (c != 0) begin
                if (c == 1) hit = 1;
                c = c - 1;
            end else if (os) begin
                c = c;
            end else if (per) begin
                c = bg & m;
            end else begin
                c = m;
            end
        end
        return c;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] e;
        int at, c, cm;
        bit h;

        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 0;

        // R1: everything clear after reset
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(12'h000, d, at); chk("R1 mask", d, 0);
        rd(12'h004, d, at); chk("R1 raw", d, 0);
        for (int ch = 0; ch < 4; ch++) begin
            rd(ch_addr(ch, 1), d, at); chk("R1 count", d, 0);
            rd(ch_addr(ch, 2), d, at); chk("R1 ctrl", d, 0);
            rd(ch_addr(ch, 3), d, at); chk("R1 bg", d, 0);
        end

        // R2 and R11: unmapped offsets, control readback with reserved bits dropped
        rd(12'h050, d, at); chk("R2 beyond ch3", d, 0);
        rd(12'hFF0, d, at); chk("R2 high offset", d, 0);
        rd(12'h00C, d, at); chk("R2 clear reads zero", d, 0);
        wr(ch_addr(2, 3), 32'h1234, c);
        wr(ch_addr(2, 2), 32'hFFFF_FFFF, c);
        rd(ch_addr(2, 2), d, at); chk("R11 ctrl readback", d, 32'hCF);
        wr(ch_addr(2, 2), 32'h0, c);
        rd(ch_addr(2, 0), d, at); chk("R2 load reads bg", d, 32'h1234);
        wr(ch_addr(2, 1), 32'h77, c);
        rd(ch_addr(2, 1), d, at); chk("R2 count read only", d, 32'h1234);

        // R3 and R7: load copies into background, background write leaves count alone
        wr(ch_addr(3, 0), 32'd20, c);
        rd(ch_addr(3, 3), d, at); chk("R3 load copies bg", d, 32'd20);
        wr(ch_addr(3, 2), 32'hC0, cm);
        wr(ch_addr(3, 3), 32'd7, c);
        rd(ch_addr(3, 1), d, at);
        chk("R7 count after bg write", d, model(20, 7, 0, 1, 0, at - cm, h));
        idle(20);
        rd(ch_addr(3, 1), d, at);
        chk("R7 periodic reload from bg", d, model(20, 7, 0, 1, 0, at - cm, h));
        wr(ch_addr(3, 2), 32'h0, c);
        wr(12'h00C, 32'hF, c);

        // R6: 16-bit and 32-bit free-running wrap
        wr(ch_addr(1, 0), 32'h0003_0002, c);
        wr(ch_addr(1, 2), 32'h80, cm);
        idle(3);
        rd(ch_addr(1, 1), d, at);
        chk("R6 16-bit wrap", d, model(32'h0003_0002, 0, 0, 0, 0, at - cm, h));
        wr(ch_addr(1, 2), 32'h0, c);
        wr(ch_addr(0, 0), 32'd1, c);
        wr(ch_addr(0, 2), 32'h82, cm);
        rd(ch_addr(0, 1), d, at);
        chk("R6 32-bit wrap", d, model(1, 0, 1, 0, 0, at - cm, h));
        wr(ch_addr(0, 2), 32'h0, c);
        wr(12'h00C, 32'hF, c);

        // R4: divide by 256 for code 11
        wr(ch_addr(1, 0), 32'd3, c);
        wr(ch_addr(1, 2), 32'h8C, cm);
        idle(300);
        rd(ch_addr(1, 1), d, at);
        chk("R4 code 11 divides by 256", d, model(3, 3, 0, 0, 0, (at - cm) / 256, h));
        wr(ch_addr(1, 2), 32'h0, c);

        // R5 and R8: one-shot parks at zero, re-enable reloads from background
        wr(ch_addr(0, 0), 32'd3, c);
        wr(ch_addr(0, 2), 32'h81, c);
        idle(20);
        rd(ch_addr(0, 1), d, at); chk("R8 one-shot parks", d, 0);
        rd(12'h004, d, at); chk("R5 raw bit0", d, 32'h1);
        wr(ch_addr(0, 2), 32'h0, c);
        wr(ch_addr(0, 3), 32'h55, c);
        wr(ch_addr(0, 2), 32'h89, c);
        rd(ch_addr(0, 1), d, at); chk("R8 re-enable reloads", d, 32'h55);
        wr(ch_addr(0, 2), 32'h0, c);
        wr(12'h00C, 32'hF, c);

        // R10: mask, masked view, selective clear, interrupt line
        wr(12'h000, 32'h2, c);
        wr(ch_addr(1, 0), 32'd2, c);
        wr(ch_addr(1, 2), 32'h80, c);
        idle(10);
        wr(ch_addr(1, 2), 32'h0, c);
        chk("R10 irq high", {31'b0, irq_o}, 32'h1);
        rd(12'h008, d, at); chk("R10 masked", d, 32'h2);
        wr(ch_addr(0, 0), 32'd1, c);
        wr(ch_addr(0, 2), 32'h80, c);
        idle(5);
        wr(ch_addr(0, 2), 32'h0, c);
        rd(12'h004, d, at); chk("R5 raw both", d, 32'h3);
        rd(12'h008, d, at); chk("R10 masked one", d, 32'h2);
        wr(12'h00C, 32'h1, c);
        rd(12'h004, d, at); chk("R10 selective clear", d, 32'h2);
        wr(12'h000, 32'h0, c);
        chk("R10 irq masked off", {31'b0, irq_o}, 32'h0);
        wr(12'h00C, 32'h2, c);
        rd(12'h004, d, at); chk("R10 clear rest", d, 32'h0);

        // random mixes of channel, mode, divider, load and wait
        for (int it = 0; it < 20; it++) begin
            int ch, code, n, ld, wt;
            bit per, os, w32;
            ch   = int'($urandom % 4);
            code = int'($urandom % 4);
            n    = div_of(code);
            per  = 1'($urandom);
            os   = 1'($urandom);
            w32  = 1'($urandom);
            ld   = (n == 256) ? 1 + int'($urandom % 6) : 1 + int'($urandom % 60);
            wt   = int'($urandom % (n * (ld + 4) + 1));
            wr(ch_addr(ch, 0), 32'(ld), c);
            wr(ch_addr(ch, 2), {24'b0, 1'b1, per, 2'b00, 2'(code), w32, os}, cm);
            idle(wt);
            rd(ch_addr(ch, 1), d, at);
            e = model(32'(ld), 32'(ld), w32, per, os, (at - cm) / n, h);
            chk("R4 random count", d, e);
            rd(12'h004, d, at);
            e = model(32'(ld), 32'(ld), w32, per, os, (at - cm) / n, h);
            chk("R5 random raw", d, h ? (32'h1 << ch) : 32'h0);
            wr(ch_addr(ch, 2), 32'h0, c);
            rd(ch_addr(ch, 1), e, at);
            idle(40);
            rd(ch_addr(ch, 1), d, at);
            chk("R9 disabled holds", d, e);
            wr(12'h00C, 32'hF, c);
        end

        summary();
        $finish;
    end
endmodule